// File: doc/BRIEF.md
# Character Row Line-Repeat Scaler

This block stretches a character cell of 18 font scan lines vertically. It repeats selected scan lines, so a text row can fill a taller display band without any change to the font data. For every output scan line that the display timing requests, it reports which font line (0 to 17) to fetch and whether that line is the second copy of a repeated line. A one-cycle pulse marks the last output line of each character row.

The amount of stretch is set by a 5-bit repeat code. Codes 0 to 15 are binary weights. Each set bit adds its own evenly spread group of repeated lines, so a row grows by exactly the code value. Codes 16 and up select three fixed, extended patterns. The code is captured only at a vertical sync or at a row boundary, so a change never splits a row. A vertical sync input restarts the line sequence at font line 0.

Output lines leave as a stream with a valid pulse and no ready signal. The block makes one output line for each accepted strobe. It cannot stall the raster, so there is no back-pressure: the consumer must take each line in the cycle where `line_vld_o` is high. `row_o` and `dup_o` hold their values between pulses.

Top module: `line_repeat_scaler`

## Requirements
- R1: For codes 0 to 15, code bit 0 (+1) repeats font line 8. Bit 1 (+2) repeats lines 4 and 12. Bit 2 (+4) repeats lines 2, 6, 10 and 14. Bit 3 (+8) repeats the odd lines 1 to 15. The repeated set is the union of the groups of the set bits.
- R2: A repeated line is emitted twice in a row, first with `dup_o`=0 and then with `dup_o`=1. A line that is not repeated is emitted once, with `dup_o`=0. The lines leave in ascending order.
- R3: For codes 0 to 15, one character row spans 18 plus the code value output lines.
- R4: Code 16 repeats lines 1 to 16 (34 lines per row). Code 17 repeats lines 0 to 16 (35 lines). Any code of 18 or more repeats all 18 lines (36 lines).
- R5: A strobe sampled high, with `vsync_i` low, makes `line_vld_o` high for exactly the next cycle, with `row_o` and `dup_o` updated on the same edge. With no accepted strobe, `line_vld_o` stays low and `row_o`/`dup_o` keep their values.
- R6: `row_end_o` pulses together with the last output copy of font line 17, and with no other line. The strobe after it yields line 0 with `dup_o`=0.
- R7: `vsync_i` sampled high clears `row_o`, `dup_o`, `line_vld_o` and `row_end_o` on the next edge, and restarts the sequence so that the next accepted strobe yields line 0 with `dup_o`=0. A strobe in the same cycle as `vsync_i` is dropped.
- R8: The repeat code is captured when `vsync_i` is high and on the edge that emits the end-of-row line. A code change in the middle of a row does not alter the rest of that row.
- R9: After reset, all outputs are 0 and the captured code is 0, so the first row has 18 lines with no repeats, whatever `wt_code_i` holds.
- R10: `row_o` never exceeds 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | Frame restart; captures the repeat code |
| line_stb_i | input | 1 | Request for the next output scan line |
| wt_code_i | input | 5 | Repeat code, 0 to 31 |
| row_o | output | 5 | Font line to fetch for the current output line |
| dup_o | output | 1 | High on the second copy of a repeated line |
| line_vld_o | output | 1 | One-cycle pulse per emitted output line |
| row_end_o | output | 1 | Pulse with the last output line of a character row |

## Verification
The bound assertions check on every cycle that a valid pulse follows each accepted strobe and nothing else, and that a second copy always follows the first copy of the same line. They also check that the end-of-row pulse sits on line 17, that the line after it restarts at 0, that a vertical sync clears the outputs, and that the line index stays in range. Which lines repeat for each code, the row height for every code and for the extended patterns, when the code is captured, and the state after reset can only be shown by the bench. It walks whole rows and compares them with sequences built from the requirements.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  // Number of binary-weighted repeat bits in the code
  localparam int WT_BITS = 4;
  // Font lines in one character cell
  localparam int CELL_H = 18;
  // Code width: weighted bits plus the extended-pattern bit
  localparam int CODE_W = WT_BITS + 1;
  // Width of a font line index
  localparam int ROW_W = $clog2(CELL_H);
endpackage

// File: rtl/lrs_mask.sv
// Turns a repeat code into a per-line "repeat this line" mask.
module lrs_mask #(
  parameter int NB     = lrs_pkg::WT_BITS,
  parameter int CELL_H = lrs_pkg::CELL_H
) (
  input  logic [NB:0]       code_i,
  output logic [CELL_H-1:0] mask_o
);
  localparam int SPAN = 1 << NB;

  logic ext;
  logic ext_lo0;
  logic ext_lo1;

  assign ext     = code_i[NB];
  assign ext_lo0 = (code_i[NB-1:0] == '0);
  assign ext_lo1 = (code_i[NB-1:0] == NB'(1));

  for (genvar l = 0; l < CELL_H; l++) begin : g_line
    logic [NB-1:0] hit;
    // Weight bit k (value 2^k) takes lines with l mod 2^(NB-k) == 2^(NB-k-1)
    for (genvar k = 0; k < NB; k++) begin : g_bit
      localparam int  MODV = 1 << (NB - k);
      localparam bit  SEL  = (l < SPAN) && ((l % MODV) == (MODV / 2));
      if (SEL) begin : g_on
        assign hit[k] = code_i[k];
      end else begin : g_off
        assign hit[k] = 1'b0;
      end
    end
    // Extended patterns: lines 1..SPAN, lines 0..SPAN, or every line
    localparam bit IN_E0 = (l >= 1) && (l <= SPAN);
    localparam bit IN_E1 = (l <= SPAN);
    always_comb begin
      if (!ext)         mask_o[l] = |hit;
      else if (ext_lo0) mask_o[l] = IN_E0;
      else if (ext_lo1) mask_o[l] = IN_E1;
      else              mask_o[l] = 1'b1;
    end
  end
endmodule

// File: rtl/lrs_seq.sv
// Font line counter and copy phase within one character row.
module lrs_seq #(
  parameter int CELL_H = lrs_pkg::CELL_H,
  parameter int ROW_W  = lrs_pkg::ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_i,
  input  logic             stb_i,
  input  logic             rep_cur_i,
  output logic [ROW_W-1:0] row_q,
  output logic             phase_q,
  output logic             accept_o,
  output logic             wrap_o
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(CELL_H - 1);

  logic last_copy;

  assign accept_o  = stb_i & ~vsync_i;
  assign last_copy = ~(rep_cur_i & ~phase_q);
  assign wrap_o    = accept_o & last_copy & (row_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || vsync_i) begin
      row_q   <= '0;
      phase_q <= 1'b0;
    end else if (accept_o) begin
      if (!last_copy) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        row_q   <= (row_q == LAST) ? '0 : row_q + ROW_W'(1);
      end
    end
  end
endmodule

// File: rtl/line_repeat_scaler.sv
module line_repeat_scaler #(
  parameter int NB     = lrs_pkg::WT_BITS,
  parameter int CELL_H = lrs_pkg::CELL_H,
  parameter int ROW_W  = lrs_pkg::ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_i,
  input  logic             line_stb_i,
  input  logic [NB:0]      wt_code_i,
  output logic [ROW_W-1:0] row_o,
  output logic             dup_o,
  output logic             line_vld_o,
  output logic             row_end_o
);
  localparam int PADW = 1 << ROW_W;

  logic [NB:0]       wt_q;
  logic [CELL_H-1:0] mask;
  logic [PADW-1:0]   mask_pad;
  logic [ROW_W-1:0]  cur_row;
  logic              phase;
  logic              accept;
  logic              wrap;

  lrs_mask #(.NB(NB), .CELL_H(CELL_H)) u_mask (
    .code_i (wt_q),
    .mask_o (mask)
  );

  assign mask_pad = PADW'(mask);

  lrs_seq #(.CELL_H(CELL_H), .ROW_W(ROW_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync_i   (vsync_i),
    .stb_i     (line_stb_i),
    .rep_cur_i (mask_pad[cur_row]),
    .row_q     (cur_row),
    .phase_q   (phase),
    .accept_o  (accept),
    .wrap_o    (wrap)
  );

  // Code capture at frame start and at row boundaries
  always_ff @(posedge clk) begin
    if (!rst_n)              wt_q <= '0;
    else if (vsync_i || wrap) wt_q <= wt_code_i;
  end

  // Registered output stage
  always_ff @(posedge clk) begin
    if (!rst_n || vsync_i) begin
      row_o      <= '0;
      dup_o      <= 1'b0;
      line_vld_o <= 1'b0;
      row_end_o  <= 1'b0;
    end else begin
      line_vld_o <= accept;
      row_end_o  <= wrap;
      if (accept) begin
        row_o <= cur_row;
        dup_o <= phase;
      end
    end
  end
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
  parameter int NB     = lrs_pkg::WT_BITS,
  parameter int CELL_H = lrs_pkg::CELL_H,
  parameter int ROW_W  = lrs_pkg::ROW_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync_i,
  input logic             line_stb_i,
  input logic [NB:0]      wt_code_i,
  input logic [ROW_W-1:0] row_o,
  input logic             dup_o,
  input logic             line_vld_o,
  input logic             row_end_o
);
  logic [ROW_W-1:0] prev_row_q;
  logic             prev_dup_q;
  logic             prev_end_q;

  always_ff @(posedge clk) begin
    if (!rst_n || vsync_i) begin
      prev_row_q <= '0;
      prev_dup_q <= 1'b0;
      prev_end_q <= 1'b0;
    end else if (line_vld_o) begin
      prev_row_q <= row_o;
      prev_dup_q <= dup_o;
      prev_end_q <= row_end_o;
    end
  end

  p_row_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    row_o <= ROW_W'(CELL_H - 1));

  p_dup_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld_o && dup_o) |-> (row_o == prev_row_q && !prev_dup_q));

  p_vld_on_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb_i && !vsync_i) |=> line_vld_o);

  p_no_vld_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb_i || vsync_i) |=> !line_vld_o);

  p_end_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_end_o |-> (line_vld_o && row_o == ROW_W'(CELL_H - 1)));

  p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld_o && prev_end_q) |-> (row_o == '0 && !dup_o));

  p_vsync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (row_o == '0 && !dup_o && !line_vld_o && !row_end_o));
endmodule

bind line_repeat_scaler lrs_chk #(.NB(NB), .CELL_H(CELL_H), .ROW_W(ROW_W)) chk_i (.*);

// File: tb/line_repeat_scaler_tb_top.sv
`timescale 1ns/1ps
module line_repeat_scaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync_i = 1'b0;
  logic       line_stb_i = 1'b0;
  logic [4:0] wt_code_i = '0;
  logic [4:0] row_o;
  logic       dup_o;
  logic       line_vld_o;
  logic       row_end_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  line_repeat_scaler dut_i (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .line_stb_i(line_stb_i),
    .wt_code_i(wt_code_i), .row_o(row_o), .dup_o(dup_o),
    .line_vld_o(line_vld_o), .row_end_o(row_end_o)
  );

  localparam int NV = 12;
  localparam logic [4:0] VCODE [NV] = '{5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd5,
                                        5'd10, 5'd15, 5'd16, 5'd17, 5'd18, 5'd25};
  localparam int VHEIGHT [NV] = '{18, 19, 20, 22, 26, 23, 28, 33, 34, 35, 36, 36};

  function automatic logic [17:0] exp_mask(input logic [4:0] c);
    logic [17:0] m;
    if (c >= 5'd18)      m = 18'h3FFFF;
    else if (c == 5'd17) m = 18'h1FFFF;
    else if (c == 5'd16) m = 18'h1FFFE;
    else begin
      m = '0;
      if (c[0]) m |= 18'h00100;
      if (c[1]) m |= 18'h01010;
      if (c[2]) m |= 18'h04444;
      if (c[3]) m |= 18'h0AAAA;
    end
    return m;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One strobe; outputs sampled just after the edge that registers them
  task automatic strobe();
    @(negedge clk) line_stb_i = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic strobe_end();
    @(negedge clk) line_stb_i = 1'b0;
  endtask

  task automatic pulse_vsync();
    @(negedge clk) vsync_i = 1'b1;
    @(negedge clk) vsync_i = 1'b0;
  endtask

  // Walk one full row, comparing every line with the model for mask m
  task automatic run_row(input logic [17:0] m, input int exp_h, input string req);
    int er = 0;
    int ed = 0;
    int cnt = 0;
    int bad = 0;
    bit done = 0;
    while (!done && cnt < 40) begin
      strobe();
      cnt++;
      if (row_o != er[4:0] || dup_o != ed[0] || !line_vld_o) begin
        bad++;
        $display("FAIL %s line %0d: actual row %0d dup %0d vld %0d expected row %0d dup %0d",
                 req, cnt, row_o, dup_o, line_vld_o, er, ed);
      end
      done = (er == 17) && (ed == 1 || !m[17]);
      if (row_end_o != done) begin
        bad++;
        $display("FAIL R6 end pulse at line %0d: actual %0d expected %0d", cnt, row_end_o, done);
      end
      strobe_end();
      if (ed == 0 && m[er]) ed = 1;
      else begin ed = 0; er = er + 1; end
    end
    n_tests++;
    if (bad != 0) n_fail++;
    check("R3", "row height", cnt, exp_h);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wt_code_i = 5'd8;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "row_o", row_o, 0);
    check("R9", "dup_o", dup_o, 0);
    check("R9", "line_vld_o", line_vld_o, 0);
    check("R9", "row_end_o", row_end_o, 0);
    // R9: code captured as 0 at reset despite wt_code_i = 8
    run_row(18'h0, 18, "R9");

    // Table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      wt_code_i = VCODE[i];
      pulse_vsync();
      run_row(exp_mask(VCODE[i]), VHEIGHT[i], (VCODE[i] >= 5'd16) ? "R4" : "R1");
      // R6: wrap to line 0 without a vsync
      strobe();
      check("R6", "row after wrap", row_o, 0);
      check("R6", "dup after wrap", dup_o, 0);
      strobe_end();
    end

    // R5: outputs hold and no valid pulse while no strobe
    wt_code_i = 5'd0;
    pulse_vsync();
    strobe(); strobe_end();
    strobe(); strobe_end();
    repeat (5) @(negedge clk);
    check("R5", "vld idle", line_vld_o, 0);
    check("R5", "row held", row_o, 1);

    // R7: vsync mid-row restarts at line 0
    strobe(); strobe_end();
    strobe(); strobe_end();
    @(negedge clk) vsync_i = 1'b1;
    @(posedge clk); #1;
    check("R7", "row after vsync", row_o, 0);
    check("R7", "vld after vsync", line_vld_o, 0);
    @(negedge clk) vsync_i = 1'b0;
    strobe();
    check("R7", "first row after vsync", row_o, 0);
    check("R7", "first dup after vsync", dup_o, 0);
    strobe_end();

    // R7: strobe together with vsync is dropped
    strobe(); strobe_end();
    @(negedge clk) begin vsync_i = 1'b1; line_stb_i = 1'b1; end
    @(posedge clk); #1;
    check("R7", "dropped strobe vld", line_vld_o, 0);
    @(negedge clk) begin vsync_i = 1'b0; line_stb_i = 1'b0; end
    run_row(18'h0, 18, "R7");

    // R8: code change mid-row takes effect at the next row only
    wt_code_i = 5'd0;
    pulse_vsync();
    strobe(); strobe_end();
    strobe(); strobe_end();
    strobe(); strobe_end();
    wt_code_i = 5'd8;
    begin
      int rest = 0;
      int dups = 0;
      bit fin = 0;
      while (!fin && rest < 40) begin
        strobe();
        rest++;
        if (dup_o) dups++;
        fin = row_end_o;
        strobe_end();
      end
      check("R8", "remaining lines", rest, 15);
      check("R8", "repeats in old row", dups, 0);
    end
    run_row(exp_mask(5'd8), 26, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule